// File: doc/BRIEF.md
# Byte-Wide SPI Master Port with Collision Detection

This block is a master-mode SPI port for a small microcontroller, reached by software through three byte-wide registers. One 8-bit shift register sends on `mosi` and receives on `miso` at the same time, most significant bit first. Software never addresses the shift register. It only sees a data register. Writing the data register while the port is idle loads the shift register and starts a transfer. Reading the data register returns the last byte that was received.

When the eighth bit has been shifted in, the received byte is copied to a separate receive buffer. This raises a buffer-full flag and an interrupt flag. Because of this second buffer, a new transfer may start before software has collected the previous byte. A data write made while a transfer is running is dropped and latches a sticky collision flag. A byte that completes while the buffer is still full is discarded and latches a sticky overrun flag. The serial clock is the system clock divided by 4, 16 or 64, and its idle level is set by a polarity bit.

Top module: `spi_byte_port`

## Requirements
- R1: After reset the status register (address 1) reads 0x00, the control register (address 2) reads 0x00, and `sclk` and `irq` are low.
- R2: A write to the data register (address 0) while `busy` is low is accepted. The written byte appears on `mosi` most significant bit first, one bit per serial clock period, and each bit is stable at the serial clock's leading (active-going) edge.
- R3: The byte received on `miso` is sampled at the trailing edge of each serial clock period, most significant bit first. When a transfer completes, this byte is readable at address 0, and status bit 0 (buffer full) and control bit 5 (interrupt flag) are both set.
- R4: A data write while `busy` is low is accepted even when status bit 0 is still set, so the next byte can shift before the previous one is read.
- R5: A data write while `busy` is high is ignored: the byte being transmitted is unchanged. It sets control bit 7 (collision).
- R6: Control bit 7 stays set through later writes that carry a 1 in bit 7 and through later transfers. Only a control write with bit 7 equal to 0 clears it.
- R7: A read of address 0 clears status bit 0 at the next clock edge.
- R8: A transfer that completes while status bit 0 is set and address 0 is not being read leaves the receive buffer unchanged. It sets control bit 6 (overrun), which is cleared only by a control write with bit 6 equal to 0.
- R9: Control bits [1:0] select the serial clock divider: 00 gives /4, 01 gives /16, and 10 or 11 give /64. The divider is latched when a transfer starts.
- R10: Control bit 3 sets the level of `sclk` when it is idle. During a bit period, `sclk` is at the opposite level for the second half of the period.
- R11: Control bit 5 is cleared only by a control write with bit 5 equal to 0. The `irq` output equals control bit 5 AND control bit 4 (interrupt enable).
- R12: `busy` (also status bit 1) rises at the clock edge that accepts a data write and stays high for exactly 8 × divider clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sel | input | 2 | Register select: 0 data, 1 status, 2 control |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of data clears buffer full) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Interrupt request (flag gated by enable) |

## Verification
Transfers are run with transmit and receive bytes that differ from each other. The set includes single-bit patterns at either end (0x01, 0x80), all-ones, all-zeros and alternating bits. Together these separate MSB-first from LSB-first order and catch an off-by-one bit slip. They also show a loopback of `mosi` into the received byte, which would make the two bytes equal. Every divider code and both clock polarities are used, and the measured length of `busy` tells the three divide ratios apart. Directed sequences then write during a transfer, start a transfer while the buffer is full, and clear the sticky flags selectively. These sequences separate a rejected write from an accepted one and show whether the old or the new byte is kept.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // control register bit positions
  localparam int CB_COLL = 7;
  localparam int CB_OVRN = 6;
  localparam int CB_IFLG = 5;
  localparam int CB_IEN  = 4;
  localparam int CB_CPOL = 3;
endpackage

// File: rtl/spi_bit_timer.sv
module spi_bit_timer #(
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16,
  parameter int DIV_C  = 64,
  parameter int NBITS  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] div_sel,
  input  logic       cpol,
  output logic       active,
  output logic       sclk,
  output logic       bit_end,
  output logic       done
);
  localparam int DMAX = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                        : ((DIV_B > DIV_C) ? DIV_B : DIV_C);
  localparam int CW = $clog2(DMAX);
  localparam int BW = $clog2(NBITS);

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_q, lim_d, lim_sel;
  logic [BW-1:0] bit_q, bit_d;

  always_comb begin
    unique case (div_sel)
      2'b00:   lim_sel = CW'(DIV_A - 1);
      2'b01:   lim_sel = CW'(DIV_B - 1);
      default: lim_sel = CW'(DIV_C - 1);
    endcase
  end

  assign bit_end = active_q && (cnt_q == lim_q);
  assign done    = bit_end && (bit_q == BW'(NBITS - 1));
  assign active  = active_q;
  assign sclk    = active_q ? (cpol ^ (cnt_q > (lim_q >> 1))) : cpol;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    bit_d    = bit_q;
    lim_d    = lim_q;
    if (start) begin
      active_d = 1'b1;
      cnt_d    = '0;
      bit_d    = '0;
      lim_d    = lim_sel;
    end else if (active_q) begin
      if (bit_end) begin
        cnt_d = '0;
        bit_d = bit_q + 1'b1;
        if (done) active_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= '0;
      lim_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      bit_q    <= bit_d;
      lim_q    <= lim_d;
    end
  end

  assert_start_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active_q && cnt_q == '0 && bit_q == '0));
  assert_stop_after_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active_q);
endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         shift,
  input  logic         sin,
  output logic         sout,
  output logic [W-1:0] next_word
);
  logic [W-1:0] sr_q, sr_d;

  assign sout      = sr_q[W-1];
  assign next_word = {sr_q[W-2:0], sin};

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = ld_data;
    else if (shift) sr_d = next_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sr_q == $past(ld_data)));
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
  import spi_port_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  output logic       busy,
  output logic       irq
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rs_n = rst_pipe[1];

  logic active, bit_end, done;
  logic [BYTE_W-1:0] rx_word;
  logic wr_data, wr_ctrl, accept, collide, rd_clr, store, overrun;

  logic [BYTE_W-1:0] rxbuf_q, rxbuf_d;
  logic full_q, full_d, coll_q, coll_d, ovrn_q, ovrn_d, iflg_q, iflg_d;
  logic ien_q, ien_d, cpol_q, cpol_d;
  logic [1:0] div_q, div_d;

  assign wr_data = wr_en && (sel == SEL_DATA);
  assign wr_ctrl = wr_en && (sel == SEL_CTRL);
  assign rd_clr  = rd_en && (sel == SEL_DATA);
  assign accept  = wr_data && !active;
  assign collide = wr_data && active;
  assign store   = done && (!full_q || rd_clr);
  assign overrun = done && full_q && !rd_clr;

  spi_bit_timer #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .NBITS(BYTE_W)) i_timer (
    .clk(clk), .rst_n(rs_n), .start(accept), .div_sel(div_q), .cpol(cpol_q),
    .active(active), .sclk(sclk), .bit_end(bit_end), .done(done)
  );

  spi_shift_reg #(.W(BYTE_W)) i_shift (
    .clk(clk), .rst_n(rs_n), .load(accept), .ld_data(wdata), .shift(bit_end),
    .sin(miso), .sout(mosi), .next_word(rx_word)
  );

  always_comb begin
    rxbuf_d = store ? rx_word : rxbuf_q;
    full_d  = store | (full_q & ~rd_clr);
    coll_d  = collide | (coll_q & ~(wr_ctrl & ~wdata[CB_COLL]));
    ovrn_d  = overrun | (ovrn_q & ~(wr_ctrl & ~wdata[CB_OVRN]));
    iflg_d  = done    | (iflg_q & ~(wr_ctrl & ~wdata[CB_IFLG]));
    ien_d   = wr_ctrl ? wdata[CB_IEN]  : ien_q;
    cpol_d  = wr_ctrl ? wdata[CB_CPOL] : cpol_q;
    div_d   = wr_ctrl ? wdata[1:0]     : div_q;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      rxbuf_q <= '0;
      full_q  <= 1'b0;
      coll_q  <= 1'b0;
      ovrn_q  <= 1'b0;
      iflg_q  <= 1'b0;
      ien_q   <= 1'b0;
      cpol_q  <= 1'b0;
      div_q   <= 2'b00;
    end else begin
      rxbuf_q <= rxbuf_d;
      full_q  <= full_d;
      coll_q  <= coll_d;
      ovrn_q  <= ovrn_d;
      iflg_q  <= iflg_d;
      ien_q   <= ien_d;
      cpol_q  <= cpol_d;
      div_q   <= div_d;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata = rxbuf_q;
      SEL_STAT: rdata = {6'b0, active, full_q};
      SEL_CTRL: rdata = {coll_q, ovrn_q, iflg_q, ien_q, cpol_q, 1'b0, div_q};
      default:  rdata = '0;
    endcase
  end

  assign busy = active;
  assign irq  = iflg_q & ien_q;

  assert_collide_flag_R5: assert property (@(posedge clk) disable iff (!rs_n)
    collide |=> coll_q);
  assert_coll_sticky_R6: assert property (@(posedge clk) disable iff (!rs_n)
    (coll_q && !(wr_ctrl && !wdata[CB_COLL])) |=> coll_q);
  assert_done_flags_R3: assert property (@(posedge clk) disable iff (!rs_n)
    done |=> (full_q && iflg_q));
  assert_buf_hold_R8: assert property (@(posedge clk) disable iff (!rs_n)
    (full_q && !rd_clr) |=> $stable(rxbuf_q));
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rs_n)
    (rd_clr && !done) |=> !full_q);
endmodule

// File: tb/test_spi_byte_port.sv
module test_spi_byte_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sclk, mosi, busy, irq;
  logic       miso = 1'b0;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  spi_byte_port i_spi_byte_port (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .busy(busy), .irq(irq)
  );

  // slave model: at each leading sclk edge capture mosi, present next miso bit
  logic       cpol_b = 1'b0;
  logic [7:0] rx_pat = 8'h00, mosi_cap = 8'h00;
  int         k = 0;
  always @(sclk) begin
    if (busy && (sclk != cpol_b)) begin
      mosi_cap = {mosi_cap[6:0], mosi};
      if (k < 8) miso = rx_pat[7-k];
      k++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
    sel = s; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] s, output logic [7:0] d);
    sel = s; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic arm(input logic [7:0] rx);
    rx_pat = rx; k = 0; mosi_cap = 8'h00;
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (busy) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  // {cpol, div code, tx byte, rx byte}
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 2'b00, 8'hA5, 8'h3C},
    {1'b0, 2'b01, 8'h01, 8'h80},
    {1'b0, 2'b10, 8'hFF, 8'h00},
    {1'b1, 2'b00, 8'h5A, 8'hC3},
    {1'b1, 2'b11, 8'h80, 8'h01},
    {1'b0, 2'b00, 8'h00, 8'hFF}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog: transfer never finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_rd(2'd1, r); chk(r == 8'h00, "R1 status after reset", r, 8'h00);
    bus_rd(2'd2, r); chk(r == 8'h00, "R1 control after reset", r, 8'h00);
    chk(sclk == 1'b0, "R1 sclk after reset", sclk, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);

    // table-driven transfers
    for (int i = 0; i < 6; i++) begin
      logic        cp;
      logic [1:0]  dv;
      logic [7:0]  tx, rx;
      int          dexp;
      {cp, dv, tx, rx} = VEC[i];
      dexp = (dv == 2'b00) ? 4 : (dv == 2'b01) ? 16 : 64;
      cpol_b = cp;
      bus_wr(2'd2, {3'b111, 1'b0, cp, 1'b0, dv});
      chk(sclk == cp, "R10 idle sclk level", sclk, cp);
      arm(rx);
      chk(busy == 1'b0, "R12 busy low before write", busy, 0);
      bus_wr(2'd0, tx);
      chk(busy == 1'b1, "R12 busy after accepted write", busy, 1);
      wait_idle(cyc);
      chk(cyc == 8 * dexp, "R9 R12 busy length", cyc, 8 * dexp);
      chk(mosi_cap == tx, "R2 mosi byte MSB first", mosi_cap, tx);
      chk(sclk == cp, "R10 sclk idle after transfer", sclk, cp);
      bus_rd(2'd1, r); chk(r[0] == 1'b1, "R3 buffer full set", r[0], 1);
      bus_rd(2'd2, r); chk(r[5] == 1'b1, "R3 interrupt flag set", r[5], 1);
      bus_rd(2'd0, r); chk(r == rx, "R3 received byte", r, rx);
      bus_rd(2'd1, r); chk(r[0] == 1'b0, "R7 read clears full", r[0], 0);
    end

    // R5 / R6 collision
    cpol_b = 1'b0;
    bus_wr(2'd2, 8'h00);
    arm(8'h69);
    bus_wr(2'd0, 8'h96);
    repeat (3) @(negedge clk);
    bus_wr(2'd0, 8'h11);
    bus_rd(2'd2, r); chk(r[7] == 1'b1, "R5 collision flag set", r[7], 1);
    wait_idle(cyc);
    chk(mosi_cap == 8'h96, "R5 rejected write leaves tx byte", mosi_cap, 8'h96);
    bus_rd(2'd0, r); chk(r == 8'h69, "R5 rx byte after collision", r, 8'h69);
    bus_wr(2'd2, 8'h80);
    bus_rd(2'd2, r); chk(r[7] == 1'b1, "R6 write of 1 keeps collision", r[7], 1);
    arm(8'h00);
    bus_wr(2'd0, 8'h42);
    wait_idle(cyc);
    bus_rd(2'd2, r); chk(r[7] == 1'b1, "R6 transfer keeps collision", r[7], 1);
    bus_rd(2'd0, r);
    bus_wr(2'd2, 8'h00);
    bus_rd(2'd2, r); chk(r[7] == 1'b0, "R6 write of 0 clears collision", r[7], 0);

    // R4 / R8 double buffer and overrun
    arm(8'h11);
    bus_wr(2'd0, 8'h33);
    wait_idle(cyc);
    arm(8'h77);
    bus_wr(2'd0, 8'h22);
    chk(busy == 1'b1, "R4 write accepted while full", busy, 1);
    wait_idle(cyc);
    chk(mosi_cap == 8'h22, "R4 second byte transmitted", mosi_cap, 8'h22);
    bus_rd(2'd2, r); chk(r[6] == 1'b1, "R8 overrun flag set", r[6], 1);
    bus_rd(2'd0, r); chk(r == 8'h11, "R8 buffer keeps old byte", r, 8'h11);
    bus_wr(2'd2, 8'h20);
    bus_rd(2'd2, r); chk(r[6] == 1'b0, "R8 write of 0 clears overrun", r[6], 0);

    // R11 interrupt gating and clearing
    chk(irq == 1'b0, "R11 irq gated off by enable", irq, 0);
    bus_wr(2'd2, 8'h30);
    chk(irq == 1'b1, "R11 irq with enable", irq, 1);
    bus_wr(2'd2, 8'h10);
    chk(irq == 1'b0, "R11 irq cleared by write of 0", irq, 0);
    bus_rd(2'd2, r); chk(r[5] == 1'b0, "R11 flag cleared", r[5], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule